// File: doc/BRIEF.md
# General-Purpose I/O Data and Direction Bank

This block is one bank of up to 32 general-purpose I/O lines behind a small register bus. Each line has a direction bit and an output latch bit. The direction register is written as a whole word. A 1 in a direction bit makes that line an input. A 0 makes it an output, and the line's pad output-enable is then asserted.

Software never rewrites the output latch as a whole word. It writes a word to a set address, and every line whose bit is 1 goes high. It writes a word to a clear address, and every line whose bit is 1 goes low. Lines whose bit is 0 keep their level in both cases, so several agents can drive different lines without a read-modify-write race.

Pad input levels pass through a two-stage synchronizer into a readable input register. This register reports every line, outputs included, so a driven level can be read back from the pad. Because of the synchronizer, a read issued just after a pad change still returns the old level.

Register map, as word addresses on `bus_addr`:

| Address | Read | Write |
|---------|------|-------|
| 0 | direction register | direction register |
| 1 | output latch | set lines |
| 2 | output latch | clear lines |
| 3 | synchronized input register | ignored |
| 4 to 15 | zero | ignored |

Reads are combinational from `bus_addr`. Writes take effect at the clock edge where `bus_we` is high.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted, the next clock edge loads the direction register with all ones and the output latch with zero, so `pad_oe` and `pad_out` are both zero.
- R2: A write to address 0 loads bit i of the direction register with bit i of the write data, and reading address 0 returns that value.
- R3: For every line, `pad_oe` is 1 exactly when its direction bit is 0; after a direction write, `pad_oe` equals the inverse of the written bits from the next cycle on.
- R4: A write to address 1 sets to 1 every latch bit whose write-data bit is 1 and leaves every other latch bit unchanged.
- R5: A write to address 2 clears to 0 every latch bit whose write-data bit is 1 and leaves every other latch bit unchanged.
- R6: The output latch changes only on writes to address 1 or 2. It updates whether the line is an input or an output, and `pad_out` always shows the latch.
- R7: Reading address 3 returns, for every line, the `pad_in` level sampled at the clock edge two edges before the read. This holds for output lines as well as input lines.
- R8: Reading address 1 or address 2 returns the current output latch value.
- R9: When NUM_LINES is below 32, read data bits at and above NUM_LINES are zero and write-data bits there have no effect. Reads of addresses 4 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_LINES | Pad levels, asynchronous to `clk` |
| pad_out | output | NUM_LINES | Output latch driven toward the pads |
| pad_oe | output | NUM_LINES | Per-line pad output-enable |

## Verification
The bench instantiates a 24-line bank so that the unused upper bits are in play. It writes all-ones patterns into those bits and checks that they never appear in a read or on a pad. A design that forgot the mask would show them on any readback.

Set and clear writes use zero words, overlapping patterns and lines that are still inputs. A design that did a plain store, or that gated the latch by direction, would then lose or corrupt lines that should have kept their level.

The pad inputs change on every cycle while address 3 is being read, so a synchronizer one stage short or one stage long reads a neighbouring sample and fails at once. Reads of the set and clear addresses and of unmapped addresses catch a read mux that returns the wrong source.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR = 4'd0,
        REG_SET = 4'd1,
        REG_CLR = 4'd2,
        REG_IN  = 4'd3
    } reg_sel_e;

    typedef struct packed {
        logic dir_we;
        logic set_we;
        logic clr_we;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_wr(input logic we, input logic [ADDR_W-1:0] a);
        wr_strobe_t s;
        s.dir_we = we && (a == REG_DIR);
        s.set_we = we && (a == REG_SET);
        s.clr_we = we && (a == REG_CLR);
        return s;
    endfunction

endpackage

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] dir_q,
    output logic [NUM_LINES-1:0] oe
);
    // a set bit marks the line as an input
    always_ff @(posedge clk) begin
        if (rst)     dir_q <= '1;
        else if (we) dir_q <= wdata;
    end

    assign oe = ~dir_q;
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_we,
    input  logic                 clr_we,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] lat_q
);
    logic [NUM_LINES-1:0] lat_d;

    always_comb begin
        lat_d = lat_q;
        if (set_we) lat_d = lat_q | wdata;
        if (clr_we) lat_d = lat_q & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) lat_q <= '0;
        else     lat_q <= lat_d;
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NUM_LINES = 32,
    parameter int STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] async_in,
    output logic [NUM_LINES-1:0] sync_out
);
    logic [NUM_LINES-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe
);
    wr_strobe_t           strb;
    logic [NUM_LINES-1:0] wd;
    logic [NUM_LINES-1:0] dir_q;
    logic [NUM_LINES-1:0] lat_q;
    logic [NUM_LINES-1:0] in_q;
    logic [NUM_LINES-1:0] rd_sel;

    assign strb = decode_wr(bus_we, bus_addr);
    assign wd   = bus_wdata[NUM_LINES-1:0];

    gpio_dir_reg #(.NUM_LINES(NUM_LINES)) u_dir (
        .clk(clk), .rst(rst), .we(strb.dir_we), .wdata(wd),
        .dir_q(dir_q), .oe(pad_oe)
    );

    gpio_out_latch #(.NUM_LINES(NUM_LINES)) u_lat (
        .clk(clk), .rst(rst), .set_we(strb.set_we), .clr_we(strb.clr_we),
        .wdata(wd), .lat_q(lat_q)
    );

    gpio_in_sync #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(pad_in), .sync_out(in_q)
    );

    assign pad_out = lat_q;

    always_comb begin
        case (bus_addr)
            REG_DIR:          rd_sel = dir_q;
            REG_SET, REG_CLR: rd_sel = lat_q;
            REG_IN:           rd_sel = in_q;
            default:          rd_sel = '0;
        endcase
        bus_rdata                = '0;
        bus_rdata[NUM_LINES-1:0] = rd_sel;
    end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [BUS_W-1:0]     bus_wdata,
    input logic [BUS_W-1:0]     bus_rdata,
    input logic [NUM_LINES-1:0] pad_in,
    input logic [NUM_LINES-1:0] pad_out,
    input logic [NUM_LINES-1:0] pad_oe
);
    logic [1:0] live_cnt;
    always_ff @(posedge clk) begin
        if (rst)                live_cnt <= '0;
        else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pad_oe == '0) && (pad_out == '0));

    // R3
    oe_follow_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 4'd0) |=> pad_oe == ~$past(bus_wdata[NUM_LINES-1:0]));

    // R4
    set_lines_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 4'd1) |=>
            pad_out == ($past(pad_out) | $past(bus_wdata[NUM_LINES-1:0])));

    // R5
    clr_lines_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 4'd2) |=>
            pad_out == ($past(pad_out) & ~$past(bus_wdata[NUM_LINES-1:0])));

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && (bus_addr == 4'd1 || bus_addr == 4'd2)) |=> $stable(pad_out));

    // R7
    in_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (live_cnt >= 2'd2 && bus_addr == 4'd3) |->
            bus_rdata[NUM_LINES-1:0] == $past(pad_in, 2));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr > 4'd3) |-> bus_rdata == '0);
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_LINES(NUM_LINES)) chk_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
    localparam int N = 24;
    localparam logic [31:0] MASK = 32'h00FF_FFFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out;
    logic [N-1:0]  pad_oe;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    gpio_bank #(.NUM_LINES(N)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // behavioural reference
    logic [31:0] m_dir;
    logic [31:0] m_lat;
    logic [31:0] hist[$];

    always @(posedge clk) begin
        if (rst) begin
            m_dir = MASK;
            m_lat = '0;
            hist.delete();
        end else begin
            if (bus_we && bus_addr == 4'd0) m_dir = bus_wdata & MASK;
            if (bus_we && bus_addr == 4'd1) m_lat = m_lat | (bus_wdata & MASK);
            if (bus_we && bus_addr == 4'd2) m_lat = m_lat & ~bus_wdata;
            hist.push_back(32'(pad_in));
            if (hist.size() > 4) void'(hist.pop_front());
        end
    end

    function automatic logic [31:0] exp_in();
        if (hist.size() >= 2) return hist[hist.size()-2];
        return '0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare outputs at the falling edge, before new stimulus
    task automatic compare_all();
        check("R3 pad_oe", 32'(pad_oe), ~m_dir & MASK);
        check("R6 pad_out", 32'(pad_out), m_lat);
        case (bus_addr)
            4'd0: check("R2 dir readback", bus_rdata, m_dir);
            4'd1, 4'd2: check("R8 latch readback", bus_rdata, m_lat);
            4'd3: check("R7 input readback", bus_rdata, exp_in());
            default: check("R9 unmapped read", bus_rdata, 32'h0);
        endcase
    endtask

    task automatic cyc(input logic [3:0] a, input logic we, input logic [31:0] d,
                       input logic [N-1:0] pin);
        @(negedge clk);
        compare_all();
        bus_addr  = a;
        bus_we    = we;
        bus_wdata = d;
        pad_in    = pin;
    endtask

    initial begin
        logic [31:0] lfsr;
        logic [N-1:0] pin;
        pad_in = 24'h5A5A5A;
        repeat (3) @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 oe after reset", 32'(pad_oe), 32'h0);
        check("R1 out after reset", 32'(pad_out), 32'h0);
        check("R1 dir after reset", bus_rdata, MASK);

        cyc(4'd0, 1'b1, 32'hFFFF_0F0F, 24'h0);     // R2, R9 upper bits
        cyc(4'd0, 1'b0, 32'h0, 24'h0);
        cyc(4'd1, 1'b1, 32'hA5A5_A5A5, 24'h0);     // R4 on mixed in/out lines, R6
        cyc(4'd1, 1'b0, 32'h0, 24'h0);
        cyc(4'd1, 1'b1, 32'h0, 24'h0);             // R4 zero word
        cyc(4'd2, 1'b1, 32'hFF00_FFFF, 24'h0);     // R5
        cyc(4'd2, 1'b0, 32'h0, 24'h0);
        cyc(4'd2, 1'b1, 32'h0, 24'h0);             // R5 zero word
        cyc(4'd1, 1'b1, 32'hFFFF_FFFF, 24'h0);     // R4 all, R9 mask
        cyc(4'd2, 1'b1, 32'h0000_3C3C, 24'h0);
        cyc(4'd0, 1'b1, 32'h0, 24'h0);             // all outputs
        cyc(4'd3, 1'b0, 32'h0, 24'h123456);        // R7 changing pads
        cyc(4'd3, 1'b0, 32'h0, 24'hFEDCBA);
        cyc(4'd3, 1'b0, 32'h0, 24'h000001);
        cyc(4'd3, 1'b1, 32'hFFFF_FFFF, 24'h800000); // write to input reg ignored
        cyc(4'd3, 1'b0, 32'h0, pad_out);           // loop-back of outputs
        cyc(4'd3, 1'b0, 32'h0, pad_out);
        cyc(4'd3, 1'b0, 32'h0, pad_out);
        for (int a = 4; a < 16; a++) cyc(4'(a), 1'b1, 32'hFFFF_FFFF, 24'hFFFFFF); // R9
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            pin  = lfsr[N-1:0] ^ 24'(i * 7);
            cyc(4'(lfsr[5:3] & 3'd7), lfsr[9], lfsr ^ {lfsr[15:0], lfsr[31:16]}, pin);
        end
        cyc(4'd0, 1'b0, 32'h0, 24'h0);
        @(negedge clk);
        compare_all();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule